// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits between a direct-mapped cache and the next memory level. It keeps lines that the main cache has recently thrown out. When the main cache misses, it presents the missing line address on the lookup port. In the same cycle it presents the line it is about to replace on the eviction port. Every entry compares its stored line address against the lookup at once.

On a buffer hit, the stored line goes back to the main cache and the evicted line takes over the freed slot, so memory is not touched. On a full miss, the evicted line is written into the buffer. It first reuses a copy already held for the same address. If there is none, it takes an empty slot. If there is no empty slot, it displaces the least recently used entry, and a displaced entry that is dirty leaves through the writeback port.

The response comes one cycle after the lookup, which is the extra latency of a buffer hit over a main-cache hit. Tags hold the full line address, because a line from any cache index may be held.

Top module: `vc_victim_buffer`

## Requirements
- R1: After reset no entry is valid, so the first lookup misses, and rsp_valid and wb_valid are low until a lookup has been made.
- R2: rsp_valid is high in exactly the cycle after a cycle with lk_valid high, and low otherwise.
- R3: A hit requires all ADDR_W bits of lk_addr to equal a held address. It returns that line's data and dirty flag on rsp_data and rsp_dirty with rsp_hit high.
- R4: On a hit, the hit line leaves the buffer. If ev_valid is high, the evicted line (address, data, dirty) is stored in its place. A later lookup of the old address misses, and a lookup of the evicted address hits.
- R5: On a miss with ev_valid high, the evicted line is stored. Empty slots are used before any held line is displaced, and wb_valid is only raised when all entries were valid.
- R6: When the buffer is full and a new line is stored on a miss, the entry displaced is the one least recently stored or swapped in.
- R7: A displaced dirty entry appears on wb_valid, wb_addr and wb_data in the same cycle as the miss response. A displaced clean entry raises no writeback.
- R8: Storing a line whose address is already held overwrites that copy without a writeback and without displacing another entry, so no address is ever held twice.
- R9: ev_valid with lk_valid low has no effect: no response, no writeback, and the line is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Main cache missed; search the buffer |
| lk_addr | input | ADDR_W | Line address being looked up |
| ev_valid | input | 1 | The main cache is replacing a valid line this cycle |
| ev_addr | input | ADDR_W | Line address of the replaced line (differs from lk_addr) |
| ev_data | input | LINE_W | Data of the replaced line |
| ev_dirty | input | 1 | Replaced line is modified |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Line was found in the buffer |
| rsp_data | output | LINE_W | Line data on a hit |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| wb_valid | output | 1 | Displaced dirty line to be written to memory |
| wb_addr | output | ADDR_W | Line address of the written-back line |
| wb_data | output | LINE_W | Data of the written-back line |

## Verification
The miss response and the writeback of a dirty displaced entry fall in the same cycle. That cycle is provoked by filling all entries and then missing with a new evicted line while the least recently used entry is dirty. The scoreboard then expects both outputs together at the one negative edge after that lookup, with the writeback carrying the oldest line's address and data. A second collision, a buffer hit whose evicted line is already held in another entry, is driven too. There the check is that the stale copy disappears and no writeback occurs.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Action taken by the buffer in a cycle with a lookup.
  typedef enum logic [1:0] {
    OP_LOOK_ONLY = 2'd0,  // miss, nothing to store (or no lookup)
    OP_HIT_SWAP  = 2'd1,  // hit, evicted line takes the hit slot
    OP_HIT_TAKE  = 2'd2,  // hit, slot is freed
    OP_MISS_FILL = 2'd3   // miss, evicted line is stored
  } vc_op_e;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int unsigned first_one(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0]             valid_vec,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec,
  input  logic [ADDR_W-1:0]              lk_addr,
  input  logic [ADDR_W-1:0]              ev_addr,
  output logic [ENTRIES-1:0]             lk_hit_vec,
  output logic [ENTRIES-1:0]             ev_dup_vec
);
  // One comparator pair per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hit_vec[g] = valid_vec[g] && (tag_vec[g] == lk_addr);
    assign ev_dup_vec[g] = valid_vec[g] && (tag_vec[g] == ev_addr);
  end
endmodule

// File: rtl/vc_lru_rank.sv
module vc_lru_rank #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  // rank 0 = most recent, ENTRIES-1 = least recent; ranks stay a permutation.
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (touch_idx == IDX_W'(i))             rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vc_victim_buffer.sv
module vc_victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [LINE_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  import vc_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  // Entry storage
  logic [ENTRIES-1:0]             valid_q, dirty_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][LINE_W-1:0] data_q;

  // Named internal events
  logic [ENTRIES-1:0] lk_hit_vec, ev_dup_vec;
  logic               lk_hit, ev_dup, has_free, spill, touch_en;
  logic [IDX_W-1:0]   hit_idx, dup_idx, free_idx, lru_idx, fill_idx, touch_idx;
  vc_op_e             op;

  vc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .valid_vec(valid_q), .tag_vec(tag_q), .lk_addr(lk_addr), .ev_addr(ev_addr),
    .lk_hit_vec(lk_hit_vec), .ev_dup_vec(ev_dup_vec)
  );

  vc_lru_rank #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .oldest_idx(lru_idx)
  );

  assign lk_hit   = |lk_hit_vec;
  assign ev_dup   = |ev_dup_vec;
  assign has_free = ~&valid_q;
  assign hit_idx  = IDX_W'(first_one(32'(lk_hit_vec)));
  assign dup_idx  = IDX_W'(first_one(32'(ev_dup_vec)));
  assign free_idx = IDX_W'(first_one(32'(~valid_q)));

  always_comb begin
    op = OP_LOOK_ONLY;
    if (lk_valid) begin
      if (lk_hit) op = ev_valid ? OP_HIT_SWAP : OP_HIT_TAKE;
      else if (ev_valid) op = OP_MISS_FILL;
    end
  end

  // Slot for a line stored on a miss: same-address copy, then empty, then LRU.
  assign fill_idx  = ev_dup ? dup_idx : (has_free ? free_idx : lru_idx);
  assign spill     = (op == OP_MISS_FILL) && !ev_dup && !has_free && dirty_q[lru_idx];
  assign touch_en  = (op == OP_HIT_SWAP) || (op == OP_MISS_FILL);
  assign touch_idx = (op == OP_HIT_SWAP) ? hit_idx : fill_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      case (op)
        OP_HIT_SWAP: begin
          if (ev_dup) valid_q[dup_idx] <= 1'b0;  // drop stale copy elsewhere
          dirty_q[hit_idx] <= ev_dirty;
        end
        OP_HIT_TAKE:  valid_q[hit_idx] <= 1'b0;
        OP_MISS_FILL: begin
          valid_q[fill_idx] <= 1'b1;
          dirty_q[fill_idx] <= ev_dirty;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_HIT_SWAP) begin
      tag_q[hit_idx]  <= ev_addr;
      data_q[hit_idx] <= ev_data;
    end else if (op == OP_MISS_FILL) begin
      tag_q[fill_idx]  <= ev_addr;
      data_q[fill_idx] <= ev_data;
    end
  end

  // Registered response and writeback: one cycle after the lookup.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_data  <= data_q[hit_idx];
      rsp_dirty <= lk_valid && lk_hit && dirty_q[hit_idx];
      wb_valid  <= spill;
      wb_addr   <= tag_q[lru_idx];
      wb_data   <= data_q[lru_idx];
    end
  end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               ev_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] lk_hit_vec,
  input logic [ENTRIES-1:0] ev_dup_vec
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r7_wb_with_miss: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && !rsp_hit));
  a_r5_wb_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> &$past(valid_vec));
  a_r1_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> |$past(valid_vec));
  a_r8_single_lk_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
  a_r8_single_ev_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_dup_vec));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid && ev_valid) |=> $stable(valid_vec));
endmodule

bind vc_victim_buffer vc_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .ev_valid(ev_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .wb_valid(wb_valid),
  .valid_vec(valid_q), .lk_hit_vec(lk_hit_vec), .ev_dup_vec(ev_dup_vec)
);

// File: tb/sim_vc_victim_buffer.sv
module sim_vc_victim_buffer;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int LW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, ev_valid = 1'b0, ev_dirty = 1'b0;
  logic [AW-1:0] lk_addr = '0, ev_addr = '0;
  logic [LW-1:0] ev_data = '0;
  logic rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [LW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  always #10 clk = ~clk;  // 50 MHz

  vc_victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) u0 (.*);

  typedef struct { logic [AW-1:0] a; logic [LW-1:0] d; logic dy; } line_t;
  typedef struct {
    logic hit; logic [LW-1:0] d; logic dy;
    logic wb; logic [AW-1:0] wa; logic [LW-1:0] wd; string tag;
  } exp_t;

  line_t model[$];   // front = most recently stored or swapped in
  exp_t  sb[$];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [AW-1:0] A(int n);
    return AW'(n * 4099 + 'h100);
  endfunction

  function automatic int find(logic [AW-1:0] a);
    foreach (model[i]) if (model[i].a == a) return i;
    return -1;
  endfunction

  task automatic op(logic [AW-1:0] la, bit ev, logic [AW-1:0] ea,
                    logic [LW-1:0] ed, bit edy, string tag);
    exp_t e; int h; int k; line_t nl; line_t v;
    e = '{hit:0, d:'0, dy:0, wb:0, wa:'0, wd:'0, tag:tag};
    nl = '{a:ea, d:ed, dy:edy};
    h = find(la);
    if (h >= 0) begin
      e.hit = 1; e.d = model[h].d; e.dy = model[h].dy;
      model.delete(h);
      if (ev) begin
        k = find(ea);
        if (k >= 0) model.delete(k);
        model.push_front(nl);
      end
    end else if (ev) begin
      k = find(ea);
      if (k >= 0) model.delete(k);
      else if (model.size() == N) begin
        v = model.pop_back();
        if (v.dy) begin e.wb = 1; e.wa = v.a; e.wd = v.d; end
      end
      model.push_front(nl);
    end
    sb.push_back(e);
    @(negedge clk);
    lk_valid = 1; lk_addr = la; ev_valid = ev; ev_addr = ea; ev_data = ed; ev_dirty = edy;
    @(posedge clk); #1;
    lk_valid = 0; ev_valid = 0;
  endtask

  // Monitor: compare each response against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        exp_t e; bit bad;
        tests++;
        if (sb.size() == 0) begin
          fails++; $display("FAIL R2 response with nothing expected: act hit=%0b exp none", rsp_hit);
        end else begin
          e = sb.pop_front();
          bad = (rsp_hit !== e.hit) || (wb_valid !== e.wb);
          if (e.hit) bad |= (rsp_data !== e.d) || (rsp_dirty !== e.dy);
          if (e.wb)  bad |= (wb_addr !== e.wa) || (wb_data !== e.wd);
          if (bad) begin
            fails++;
            $display("FAIL %s act hit=%0b d=%h dy=%0b wb=%0b %h %h exp hit=%0b d=%h dy=%0b wb=%0b %h %h",
                     e.tag, rsp_hit, rsp_data, rsp_dirty, wb_valid, wb_addr, wb_data,
                     e.hit, e.d, e.dy, e.wb, e.wa, e.wd);
          end
        end
      end else if (wb_valid) begin
        tests++; fails++;
        $display("FAIL R7 writeback without response: act wb=1 exp wb=0");
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: act running exp finished");
    finish_run();
  end

  initial begin
    int unsigned s;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    tests++;
    if (rsp_valid !== 0 || wb_valid !== 0) begin
      fails++; $display("FAIL R1 act rsp=%0b wb=%0b exp 0 0", rsp_valid, wb_valid);
    end
    op(A(1), 0, '0, '0, 0, "R1");
    // fill empty slots
    op(A(20), 1, A(1), 64'h1111, 1, "R5");
    op(A(21), 1, A(2), 64'h2222, 0, "R5");
    op(A(22), 1, A(3), 64'h3333, 1, "R5");
    op(A(23), 1, A(4), 64'h4444, 0, "R5");
    // hits and swaps
    op(A(2), 0, '0, '0, 0, "R3");
    op(A(2), 0, '0, '0, 0, "R4");
    op(A(3), 1, A(5), 64'h5555, 1, "R4");
    op(A(5), 0, '0, '0, 0, "R4");
    op(A(3), 0, '0, '0, 0, "R4");
    op(A(1) ^ (AW'(1) << (AW-1)), 0, '0, '0, 0, "R3");
    // refill to full, then displace oldest (dirty, then clean)
    op(A(24), 1, A(6), 64'h6666, 0, "R5");
    op(A(25), 1, A(7), 64'h7777, 1, "R5");
    op(A(26), 1, A(8), 64'h8888, 1, "R6");
    op(A(27), 1, A(9), 64'h9999, 0, "R7");
    op(A(28), 1, A(10), 64'hAAAA, 0, "R7");
    op(A(29), 1, A(11), 64'hBBBB, 0, "R6");
    // same address stored again
    op(A(30), 1, A(10), 64'hA0A0, 1, "R8");
    op(A(10), 0, '0, '0, 0, "R8");
    op(A(8), 1, A(11), 64'hB0B0, 0, "R8");
    op(A(11), 0, '0, '0, 0, "R8");
    // eviction with no lookup is ignored
    @(negedge clk);
    ev_valid = 1; ev_addr = A(12); ev_data = 64'hCCCC; ev_dirty = 1;
    @(posedge clk); #1; ev_valid = 0;
    @(negedge clk);
    tests++;
    if (rsp_valid !== 0 || wb_valid !== 0) begin
      fails++; $display("FAIL R9 act rsp=%0b wb=%0b exp 0 0", rsp_valid, wb_valid);
    end
    op(A(12), 0, '0, '0, 0, "R9");
    // mixed traffic over a small address pool
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int la, ea;
      s = s * 1664525 + 1013904223; la = int'(s[20:18]);
      s = s * 1664525 + 1013904223; ea = int'(s[20:18]);
      if (ea == la) ea = (ea + 1) % 8;
      op(A(40 + la), s[9:0] < 700, A(40 + ea), {s, ~s}, s[3], "R6");
    end
    repeat (3) @(negedge clk);
    tests++;
    if (sb.size() != 0) begin
      fails++; $display("FAIL R2 act %0d pending exp 0", sb.size());
    end
    finish_run();
  end
endmodule